// File: doc/BRIEF.md
# Repeated String Transfer Engine

The engine is a hardware sequencer that runs byte or word string operations against a simple synchronous memory port. It has four operations. A move copies an element from the source string to the destination string. A load fetches a source element into an accumulator. A store writes the accumulator to the destination. A compare reads one element from each string and reports equality on a zero flag. Each operation runs either once or repeated under a count register.

The engine holds the source and destination segment and index registers, the count register, the direction bit and a 16-bit accumulator. A load strobe writes all of them at once while the engine is idle. A start pulse carries the opcode, the operand size and the repeat qualifiers. Every memory address is a 20-bit physical address, formed by shifting a 16-bit segment left by four bits and adding a 16-bit offset. A word is moved as two byte accesses, low byte first.

The controller is a single state machine with six states:
- `ST_IDLE` accepts a start and goes to the first access state, or straight to `ST_DONE` when a repeat is started with a zero count.
- `ST_RD_SRC` reads the source element. It then goes to `ST_WR_DST` for a move, `ST_RD_DST` for a compare, or `ST_STEP` for a load.
- `ST_RD_DST` reads the destination element and goes to `ST_STEP`.
- `ST_WR_DST` writes the destination element and goes to `ST_STEP`. A store starts here.
- `ST_STEP` updates the index registers, the count, the flag and the accumulator. It then either loops to the first access state of the operation or ends in `ST_DONE`.
- `ST_DONE` pulses done for one cycle and returns to `ST_IDLE`.

Top module: `strx_engine`

## Requirements
- R1: After reset, busy, done, zf and mem_req are 0, and si_o, di_o, cx_o and acc_o are all zero.
- R2: A source access uses the physical address (DS<<4)+SI, and a destination access uses (ES<<4)+DI. The result is taken modulo 2^20.
- R3: After each element, the index register an operation uses steps by 1 for a byte operation and by 2 for a word operation. It increments when the direction bit is 0 and decrements when it is 1, wrapping in 16 bits. Move and compare step both SI and DI. Load (op=01) steps only SI. Store (op=10) steps only DI.
- R4: A word (word=1) takes two byte accesses: offset first, then offset+1, with the offset wrapping in 16 bits. The first access carries bits 7:0 and the second carries bits 15:8.
- R5: A move (op=00) reads the source bytes and then writes the same bytes to the destination.
- R6: A load (op=01) writes the source element into the accumulator. A byte load keeps acc bits 15:8. A store (op=10) writes the accumulator (its low byte only, for a byte store) to the destination. Neither a load nor a store changes zf.
- R7: A compare (op=11) reads the source element and then the destination element. It sets zf to 1 when they are equal and to 0 when they differ.
- R8: With rep_en=0, exactly one element is processed and CX is unchanged. With rep_en=1, CX is decremented after every element, and the operation ends when CX reaches zero.
- R9: Starting with rep_en=1 and CX=0 produces done with no memory access. SI, DI, CX, acc and zf are left unchanged.
- R10: A repeated compare with rep_ne=0 ends after the first unequal element. With rep_ne=1 it ends after the first equal element. Either way it also ends when CX reaches zero.
- R11: While mem_req is high and mem_rdy is low, mem_req, mem_addr, mem_we and mem_wdata hold their values. An access completes in the cycle where mem_req and mem_rdy are both 1.
- R12: busy rises in the cycle after an accepted start. done is a one-cycle pulse after which busy is 0. A start while busy is ignored.
- R13: A load strobe while idle, with no start in the same cycle, writes all seven registers, and their values appear on the outputs in the next cycle. A load strobe while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld | input | 1 | Register load strobe (idle only) |
| ld_ds | input | 16 | Source segment load value |
| ld_si | input | 16 | Source index load value |
| ld_es | input | 16 | Destination segment load value |
| ld_di | input | 16 | Destination index load value |
| ld_cx | input | 16 | Count load value |
| ld_df | input | 1 | Direction bit load value (0 = up, 1 = down) |
| ld_acc | input | 16 | Accumulator load value |
| start | input | 1 | Start pulse |
| op | input | 2 | 00 move, 01 load, 10 store, 11 compare |
| word | input | 1 | 1 = word elements, 0 = byte elements |
| rep_en | input | 1 | Repeat under the count register |
| rep_ne | input | 1 | Compare only: repeat while not equal |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| zf | output | 1 | Zero flag from the last compare |
| si_o | output | 16 | Current source index |
| di_o | output | 16 | Current destination index |
| cx_o | output | 16 | Current count |
| acc_o | output | 16 | Current accumulator |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_rdy |
| mem_rdy | input | 1 | Memory ready; completes the current access |

## Verification
The assertions assume the memory side never completes an access unless a request is pending. They also assume read data is valid in the cycle where mem_rdy meets mem_req. They further assume that start and ld are synchronous pulses, so that a start accepted in idle sees the count already in the register. The stimulus keeps to these assumptions: mem_rdy and mem_rdata come from a memory model that acts only on a pending request, and the model answers with stalls drawn from a shift-register sequence. Starts and loads are driven away from the clock edge, and the stray start and load pulses sent mid-operation arrive only while the engine is busy.

// File: rtl/strx_pkg.sv
package strx_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        OP_MOVE  = 2'b00,
        OP_LOAD  = 2'b01,
        OP_STORE = 2'b10,
        OP_CMP   = 2'b11
    } strx_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SRC,
        ST_RD_DST,
        ST_WR_DST,
        ST_STEP,
        ST_DONE
    } strx_state_e;

    function automatic strx_state_e first_state(strx_op_e o);
        return (o == OP_STORE) ? ST_WR_DST : ST_RD_SRC;
    endfunction

endpackage

// File: rtl/strx_agen.sv
module strx_agen #(
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4
) (
    input  logic [OFF_W-1:0]           seg,
    input  logic [OFF_W-1:0]           off,
    input  logic                       hi,
    output logic [OFF_W+SEG_SHIFT-1:0] pa
);
    localparam int PA_W = OFF_W + SEG_SHIFT;

    logic [OFF_W-1:0] off_b;
    logic [PA_W-1:0]  seg_base;

    // the high byte of a word sits at offset+1, wrapping inside the segment
    assign off_b    = off + OFF_W'(hi);
    assign seg_base = {seg, {SEG_SHIFT{1'b0}}};
    assign pa       = seg_base + PA_W'(off_b);

endmodule

// File: rtl/strx_step.sv
module strx_step #(
    parameter int OFF_W = 16
) (
    input  logic [OFF_W-1:0] idx,
    input  logic             word,
    input  logic             dir,
    output logic [OFF_W-1:0] nxt
);
    logic [OFF_W-1:0] delta;

    assign delta = word ? OFF_W'(2) : OFF_W'(1);
    assign nxt   = dir ? (idx - delta) : (idx + delta);

endmodule

// File: rtl/strx_match.sv
module strx_match
    import strx_pkg::*;
(
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic              word,
    output logic              eq
);
    logic eq_lo, eq_hi;

    assign eq_lo = (a[BYTE_W-1:0] == b[BYTE_W-1:0]);
    assign eq_hi = (a[WORD_W-1:BYTE_W] == b[WORD_W-1:BYTE_W]);
    assign eq    = eq_lo & (eq_hi | ~word);

endmodule

// File: rtl/strx_engine.sv
module strx_engine
    import strx_pkg::*;
#(
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int PA_W     = OFF_W + SEG_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [OFF_W-1:0]  ld_ds,
    input  logic [OFF_W-1:0]  ld_si,
    input  logic [OFF_W-1:0]  ld_es,
    input  logic [OFF_W-1:0]  ld_di,
    input  logic [OFF_W-1:0]  ld_cx,
    input  logic              ld_df,
    input  logic [WORD_W-1:0] ld_acc,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic              word,
    input  logic              rep_en,
    input  logic              rep_ne,
    output logic              busy,
    output logic              done,
    output logic              zf,
    output logic [OFF_W-1:0]  si_o,
    output logic [OFF_W-1:0]  di_o,
    output logic [OFF_W-1:0]  cx_o,
    output logic [WORD_W-1:0] acc_o,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_rdy
);
    localparam int NIDX = 2;   // 0: source side, 1: destination side

    strx_state_e state_q, state_d;

    logic [OFF_W-1:0]  ds_q, si_q, es_q, di_q, cx_q;
    logic              df_q, zf_q;
    logic [WORD_W-1:0] acc_q, tsrc_q, tdst_q;
    strx_op_e          op_q;
    logic              word_q, rep_q, ne_q, hi_q;

    logic              fire, last_byte, eq, stop;
    logic [OFF_W-1:0]  cx_n;
    logic              use_src, use_dst;
    logic [WORD_W-1:0] wr_word;

    logic [OFF_W-1:0]  seg_sel [NIDX];
    logic [OFF_W-1:0]  idx_cur [NIDX];
    logic [OFF_W-1:0]  idx_nxt [NIDX];
    logic [PA_W-1:0]   pa_sel  [NIDX];

    assign seg_sel[0] = ds_q;
    assign seg_sel[1] = es_q;
    assign idx_cur[0] = si_q;
    assign idx_cur[1] = di_q;

    // one address generator and one index stepper per string side
    for (genvar g = 0; g < NIDX; g++) begin : g_side
        strx_agen #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)) u_agen (
            .seg (seg_sel[g]),
            .off (idx_cur[g]),
            .hi  (hi_q),
            .pa  (pa_sel[g])
        );
        strx_step #(.OFF_W(OFF_W)) u_step (
            .idx  (idx_cur[g]),
            .word (word_q),
            .dir  (df_q),
            .nxt  (idx_nxt[g])
        );
    end

    strx_match u_match (
        .a    (tsrc_q),
        .b    (tdst_q),
        .word (word_q),
        .eq   (eq)
    );

    assign fire      = mem_req & mem_rdy;
    assign last_byte = ~word_q | hi_q;
    assign use_src   = (op_q != OP_STORE);
    assign use_dst   = (op_q != OP_LOAD);
    assign cx_n      = rep_q ? (cx_q - OFF_W'(1)) : cx_q;
    assign wr_word   = (op_q == OP_MOVE) ? tsrc_q : acc_q;

    always_comb begin
        stop = 1'b0;
        if (!rep_q || cx_n == '0) begin
            stop = 1'b1;
        end else if (op_q == OP_CMP) begin
            stop = ne_q ? eq : ~eq;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (rep_en && cx_q == '0) state_d = ST_DONE;
                    else                      state_d = first_state(strx_op_e'(op));
                end
            end
            ST_RD_SRC: begin
                if (fire && last_byte) begin
                    unique case (op_q)
                        OP_MOVE: state_d = ST_WR_DST;
                        OP_CMP:  state_d = ST_RD_DST;
                        default: state_d = ST_STEP;
                    endcase
                end
            end
            ST_RD_DST: if (fire && last_byte) state_d = ST_STEP;
            ST_WR_DST: if (fire && last_byte) state_d = ST_STEP;
            ST_STEP:   state_d = stop ? ST_DONE : first_state(op_q);
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // architectural and staging registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ds_q   <= '0;
            si_q   <= '0;
            es_q   <= '0;
            di_q   <= '0;
            cx_q   <= '0;
            df_q   <= 1'b0;
            zf_q   <= 1'b0;
            acc_q  <= '0;
            tsrc_q <= '0;
            tdst_q <= '0;
            op_q   <= OP_MOVE;
            word_q <= 1'b0;
            rep_q  <= 1'b0;
            ne_q   <= 1'b0;
            hi_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q   <= strx_op_e'(op);
                        word_q <= word;
                        rep_q  <= rep_en;
                        ne_q   <= rep_ne;
                        hi_q   <= 1'b0;
                    end else if (ld) begin
                        ds_q  <= ld_ds;
                        si_q  <= ld_si;
                        es_q  <= ld_es;
                        di_q  <= ld_di;
                        cx_q  <= ld_cx;
                        df_q  <= ld_df;
                        acc_q <= ld_acc;
                    end
                end
                ST_RD_SRC: begin
                    if (fire) begin
                        tsrc_q <= hi_q ? {mem_rdata, tsrc_q[BYTE_W-1:0]}
                                       : {tsrc_q[WORD_W-1:BYTE_W], mem_rdata};
                        hi_q   <= word_q & ~hi_q;
                    end
                end
                ST_RD_DST: begin
                    if (fire) begin
                        tdst_q <= hi_q ? {mem_rdata, tdst_q[BYTE_W-1:0]}
                                       : {tdst_q[WORD_W-1:BYTE_W], mem_rdata};
                        hi_q   <= word_q & ~hi_q;
                    end
                end
                ST_WR_DST: begin
                    if (fire) hi_q <= word_q & ~hi_q;
                end
                ST_STEP: begin
                    if (use_src) si_q <= idx_nxt[0];
                    if (use_dst) di_q <= idx_nxt[1];
                    cx_q <= cx_n;
                    if (op_q == OP_CMP) zf_q <= eq;
                    if (op_q == OP_LOAD) begin
                        acc_q <= word_q ? tsrc_q : {acc_q[WORD_W-1:BYTE_W], tsrc_q[BYTE_W-1:0]};
                    end
                    hi_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        mem_req   = (state_q == ST_RD_SRC) || (state_q == ST_RD_DST) || (state_q == ST_WR_DST);
        mem_we    = (state_q == ST_WR_DST);
        mem_addr  = (state_q == ST_RD_SRC) ? pa_sel[0] : pa_sel[1];
        mem_wdata = hi_q ? wr_word[WORD_W-1:BYTE_W] : wr_word[BYTE_W-1:0];
        zf        = zf_q;
        si_o      = si_q;
        di_o      = di_q;
        cx_o      = cx_q;
        acc_o     = acc_q;
    end

    // R11: a stalled access keeps its request and payload
    a_r11_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R12: done lasts one cycle and is followed by idle
    a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9: a repeat started on a zero count finishes at once
    a_r9_empty_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && rep_en && cx_q == '0) |=> (done && !mem_req));

    // R8: a repeated element consumes exactly one count
    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && rep_q) |=> (cx_q == $past(cx_q) - OFF_W'(1)));

    // R6: only a compare touches the flag
    a_r6_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && op_q != OP_CMP) |=> $stable(zf_q));

    // R13: loads are refused while an operation runs
    a_r13_load_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q != ST_STEP) |=> ($stable(ds_q) && $stable(es_q) && $stable(df_q)));

endmodule

// File: tb/tb_strx_engine.sv
module tb_strx_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld = 1'b0;
    logic [15:0] ld_ds = '0, ld_si = '0, ld_es = '0, ld_di = '0, ld_cx = '0;
    logic        ld_df = 1'b0;
    logic [15:0] ld_acc = '0;
    logic        start = 1'b0;
    logic [1:0]  op_i = '0;
    logic        word = 1'b0, rep_en = 1'b0, rep_ne = 1'b0;
    logic        busy, done, zf;
    logic [15:0] si_o, di_o, cx_o, acc_o;
    logic        mem_req, mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_rdy = 1'b0;

    always #2 clk = ~clk;

    strx_engine dut (
        .clk(clk), .rst_n(rst_n), .ld(ld), .ld_ds(ld_ds), .ld_si(ld_si), .ld_es(ld_es),
        .ld_di(ld_di), .ld_cx(ld_cx), .ld_df(ld_df), .ld_acc(ld_acc), .start(start),
        .op(op_i), .word(word), .rep_en(rep_en), .rep_ne(rep_ne), .busy(busy), .done(done),
        .zf(zf), .si_o(si_o), .di_o(di_o), .cx_o(cx_o), .acc_o(acc_o), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rdy(mem_rdy)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string cur_tag = "R11";
    bit stall = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [7:0] mem [int];
    logic [7:0] mm  [int];
    int         qa  [$];
    bit         qwe [$];
    logic [7:0] qd  [$];

    logic [15:0] m_ds = '0, m_si = '0, m_es = '0, m_di = '0, m_cx = '0, m_acc = '0;
    bit          m_df = 1'b0, m_zf = 1'b0;

    function automatic logic [7:0] bg(int a);
        return 8'((a ^ (a >> 8)) ^ 32'h5A);
    endfunction

    function automatic logic [7:0] mrd(int a);
        if (mem.exists(a)) return mem[a];
        return bg(a);
    endfunction

    function automatic logic [7:0] mmrd(int a);
        if (mm.exists(a)) return mm[a];
        return bg(a);
    endfunction

    function automatic int pa(logic [15:0] s, logic [15:0] o);
        return ((int'(s) << 4) + int'(o)) & 32'hFFFFF;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push(int a, bit w, logic [7:0] d);
        qa.push_back(a);
        qwe.push_back(w);
        qd.push_back(d);
    endtask

    // behavioural reference: expected access list and final register state
    task automatic model_run(logic [1:0] op, bit wd, bit re, bit ne);
        logic [7:0]  s [2];
        logic [7:0]  d [2];
        logic [15:0] dl;
        logic [7:0]  av [2];
        int          nb;
        int          a;
        bit          eq;
        mm = mem;
        nb = wd ? 2 : 1;
        dl = wd ? 16'd2 : 16'd1;
        if (re && m_cx == 16'd0) return;
        forever begin
            s[0] = '0; s[1] = '0; d[0] = '0; d[1] = '0;
            av[0] = m_acc[7:0]; av[1] = m_acc[15:8];
            if (op != 2'b10) begin
                for (int b = 0; b < nb; b++) begin
                    a = pa(m_ds, m_si + 16'(b));
                    push(a, 1'b0, 8'h00);
                    s[b] = mmrd(a);
                end
            end
            if (op == 2'b00 || op == 2'b10) begin
                for (int b = 0; b < nb; b++) begin
                    a = pa(m_es, m_di + 16'(b));
                    push(a, 1'b1, (op == 2'b00) ? s[b] : av[b]);
                    mm[a] = (op == 2'b00) ? s[b] : av[b];
                end
            end
            if (op == 2'b11) begin
                for (int b = 0; b < nb; b++) begin
                    a = pa(m_es, m_di + 16'(b));
                    push(a, 1'b0, 8'h00);
                    d[b] = mmrd(a);
                end
            end
            if (op == 2'b01) m_acc = wd ? {s[1], s[0]} : {m_acc[15:8], s[0]};
            eq = (s[0] == d[0]) && (!wd || s[1] == d[1]);
            if (op == 2'b11) m_zf = eq;
            if (op != 2'b10) m_si = m_df ? m_si - dl : m_si + dl;
            if (op != 2'b01) m_di = m_df ? m_di - dl : m_di + dl;
            if (!re) break;
            m_cx = m_cx - 16'd1;
            if (m_cx == 16'd0) break;
            if (op == 2'b11 && (ne ? eq : !eq)) break;
        end
    endtask

    // memory model: answers a pending request, sometimes after stalls (R11)
    always @(negedge clk) begin
        bit rdy_n;
        int a;
        bit w;
        logic [7:0] d;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rdy_n = stall ? (lfsr[0] & lfsr[2]) : 1'b1;
        if (rst_n && rdy_n && mem_req) begin
            if (qa.size() == 0) begin
                chk({cur_tag, " R11"}, "unexpected access", int'(mem_addr), -1);
            end else begin
                a = qa.pop_front();
                w = qwe.pop_front();
                d = qd.pop_front();
                chk({cur_tag, " R2"}, "address", int'(mem_addr), a);
                chk(cur_tag, "direction", int'(mem_we), int'(w));
                if (w) chk(cur_tag, "write data", int'(mem_wdata), int'(d));
            end
            if (mem_we) mem[int'(mem_addr)] = mem_wdata;
            else        mem_rdata = mrd(int'(mem_addr));
        end
        mem_rdy = rdy_n;
    end

    task automatic load(logic [15:0] ds, logic [15:0] si, logic [15:0] es, logic [15:0] di,
                        logic [15:0] cx, bit df, logic [15:0] acc);
        @(negedge clk);
        ld_ds = ds; ld_si = si; ld_es = es; ld_di = di; ld_cx = cx; ld_df = df; ld_acc = acc;
        ld = 1'b1;
        m_ds = ds; m_si = si; m_es = es; m_di = di; m_cx = cx; m_df = df; m_acc = acc;
        @(negedge clk);
        ld = 1'b0;
        chk("R13", "loaded si", int'(si_o), int'(si));
        chk("R13", "loaded cx", int'(cx_o), int'(cx));
    endtask

    task automatic run(logic [1:0] op, bit wd, bit re, bit ne, string tag, bit disturb);
        int cycles;
        model_run(op, wd, re, ne);
        cur_tag = tag;
        @(negedge clk);
        op_i = op; word = wd; rep_en = re; rep_ne = ne; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R12"}, "busy after start", int'(busy), 1);
        cycles = 0;
        while (!done && cycles < 3000) begin
            if (disturb && cycles == 1) begin
                start = 1'b1; op_i = ~op; rep_en = 1'b0;
                ld = 1'b1; ld_ds = 16'hDEAD; ld_si = 16'hBEEF; ld_cx = 16'h0007; ld_acc = 16'h1111;
            end else begin
                start = 1'b0; ld = 1'b0;
            end
            @(negedge clk);
            cycles++;
        end
        start = 1'b0; ld = 1'b0;
        chk({tag, " R12"}, "done reached", int'(cycles < 3000), 1);
        @(negedge clk);
        chk({tag, " R12"}, "done single pulse", int'(done), 0);
        chk({tag, " R12"}, "idle after done", int'(busy), 0);
        chk(tag, "accesses left over", qa.size(), 0);
        qa.delete(); qwe.delete(); qd.delete();
        chk(tag, "si", int'(si_o), int'(m_si));
        chk(tag, "di", int'(di_o), int'(m_di));
        chk({tag, " R8"}, "cx", int'(cx_o), int'(m_cx));
        chk(tag, "acc", int'(acc_o), int'(m_acc));
        chk(tag, "zf", int'(zf), int'(m_zf));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "zf", int'(zf), 0);
        chk("R1", "mem_req", int'(mem_req), 0);
        chk("R1", "si", int'(si_o), 0);
        chk("R1", "cx", int'(cx_o), 0);
        chk("R1", "acc", int'(acc_o), 0);

        // R5 single byte move
        load(16'h1000, 16'h0010, 16'h2000, 16'h0020, 16'd1, 1'b0, 16'h0000);
        run(2'b00, 1'b0, 1'b0, 1'b0, "R5", 1'b0);

        // R4 R8 repeated word move with stalls
        stall = 1'b1;
        load(16'h1000, 16'h0040, 16'h2000, 16'h0060, 16'd4, 1'b0, 16'h0000);
        run(2'b00, 1'b1, 1'b1, 1'b0, "R4 R8", 1'b0);

        // R3 downward repeated byte move
        load(16'h1000, 16'h0080, 16'h3000, 16'h0090, 16'd3, 1'b1, 16'h0000);
        run(2'b00, 1'b0, 1'b1, 1'b0, "R3", 1'b0);

        // R6 word load, then byte load keeping the upper byte
        stall = 1'b0;
        load(16'h1000, 16'h0200, 16'h2000, 16'h0200, 16'd1, 1'b0, 16'h1234);
        run(2'b01, 1'b1, 1'b0, 1'b0, "R6", 1'b0);
        run(2'b01, 1'b0, 1'b0, 1'b0, "R6", 1'b0);

        // R6 R3 repeated downward word store
        load(16'h1000, 16'h0000, 16'h4000, 16'h0300, 16'd3, 1'b1, 16'hA55A);
        run(2'b10, 1'b1, 1'b1, 1'b0, "R6 R3", 1'b0);

        // R10 R7 repeat-while-equal stops on third byte
        mem[32'h10400] = 8'h11; mem[32'h10401] = 8'h22; mem[32'h10402] = 8'h33;
        mem[32'h10403] = 8'h44; mem[32'h10404] = 8'h55;
        mem[32'h20400] = 8'h11; mem[32'h20401] = 8'h22; mem[32'h20402] = 8'h99;
        mem[32'h20403] = 8'h44; mem[32'h20404] = 8'h55;
        load(16'h1000, 16'h0400, 16'h2000, 16'h0400, 16'd5, 1'b0, 16'h0000);
        run(2'b11, 1'b0, 1'b1, 1'b0, "R10 R7", 1'b0);
        chk("R10", "count after early stop", int'(cx_o), 2);

        // R10 repeat-while-not-equal stops on first match
        mem[32'h10500] = 8'h01; mem[32'h10501] = 8'h02; mem[32'h10502] = 8'h03; mem[32'h10503] = 8'h04;
        mem[32'h20500] = 8'h09; mem[32'h20501] = 8'h08; mem[32'h20502] = 8'h03; mem[32'h20503] = 8'h07;
        load(16'h1000, 16'h0500, 16'h2000, 16'h0500, 16'd4, 1'b0, 16'h0000);
        run(2'b11, 1'b0, 1'b1, 1'b1, "R10", 1'b0);
        chk("R10", "flag on match", int'(zf), 1);

        // R7 single word compares: unequal then equal
        mem[32'h10600] = 8'hC3; mem[32'h10601] = 8'h3C;
        mem[32'h20600] = 8'hC3; mem[32'h20601] = 8'h3D;
        mem[32'h10602] = 8'h77; mem[32'h10603] = 8'h66;
        mem[32'h20602] = 8'h77; mem[32'h20603] = 8'h66;
        load(16'h1000, 16'h0600, 16'h2000, 16'h0600, 16'd9, 1'b0, 16'h0000);
        run(2'b11, 1'b1, 1'b0, 1'b0, "R7", 1'b0);
        chk("R7", "flag on mismatch", int'(zf), 0);
        run(2'b11, 1'b1, 1'b0, 1'b0, "R7", 1'b0);
        chk("R7", "flag on equal", int'(zf), 1);

        // R9 repeat with zero count: no access, nothing changes
        load(16'h1000, 16'h0700, 16'h2000, 16'h0700, 16'd0, 1'b0, 16'h4321);
        run(2'b00, 1'b1, 1'b1, 1'b0, "R9", 1'b0);
        run(2'b11, 1'b0, 1'b1, 1'b0, "R9", 1'b0);

        // R2 R4 offset and physical address wrap
        load(16'hF800, 16'hFFFF, 16'hFFFF, 16'hFFF0, 16'd2, 1'b0, 16'h0000);
        run(2'b00, 1'b1, 1'b1, 1'b0, "R2 R4", 1'b0);

        // R12 R13 stray start and load while busy are ignored
        stall = 1'b1;
        load(16'h1000, 16'h0800, 16'h2000, 16'h0900, 16'd6, 1'b0, 16'h0F0F);
        run(2'b00, 1'b0, 1'b1, 1'b0, "R12 R13", 1'b1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule